// File: doc/BRIEF.md
# Single-Cycle 32-bit Six-Instruction Processor Core

This block is a 32-bit processor core in which every instruction completes in exactly one clock. The supported set is six instructions: register add, OR with immediate, load word, store word, branch when two registers are equal, and unconditional jump. Each cycle the core presents the current program counter as the instruction address and decodes the returned word. It reads two registers, runs the ALU, optionally reads or writes the data memory, writes one register back and loads the next program counter on the clock edge.

The core contains a 32-entry by 32-bit register file with two read ports and one write port. It also holds the opcode and function decode, the operand and destination selectors, the zero and sign extenders, and the next-address logic. Instruction and data memories sit outside the block. Each is read combinationally within the cycle, and the data memory takes a write on the clock edge when `dmem_we` is high.

Instruction fields are fixed: opcode in bits [31:26], first source register in [25:21], second source register in [20:16], destination register in [15:11], shift amount in [10:6], function code in [5:0], immediate in [15:0] and jump target in [25:0].

Top module: `onecycle_core`

## Requirements
- R1: While `rst` is high, `imem_addr` is 0 and `dmem_we` is 0. The first instruction fetched after `rst` falls is at address 0.
- R2: Opcode 0x00 with function code 0x20 and a zero shift amount writes rs + rt (modulo 2^32) into register rd. The program counter then advances by 4.
- R3: Opcode 0x0D writes rs OR the 16-bit immediate, zero-extended to 32 bits, into register rt. The program counter then advances by 4.
- R4: Opcode 0x23 presents rs + sign-extended immediate on `dmem_addr` and writes the returned word `dmem_rdata` into register rt. The program counter then advances by 4.
- R5: Opcode 0x2B raises `dmem_we` for that cycle only, with `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = the value of rt. No register is written.
- R6: Opcode 0x04 compares rs and rt by subtraction. If they are equal, the next address is PC + 4 + (sign-extended immediate × 4). Otherwise it is PC + 4. Negative offsets move backwards.
- R7: Opcode 0x02 sets the next address to bits [31:28] of PC + 4, followed by the 26-bit target, followed by two zero bits.
- R8: Register 0 always reads as zero. Any write aimed at it is dropped.
- R9: Any other opcode, or opcode 0x00 with a function code other than 0x20 or a nonzero shift amount, writes no register and no memory, and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to execute (registered program counter) |
| imem_instr | input | 32 | Instruction word at `imem_addr`, returned in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or a store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store instruction |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, returned in the same cycle |

## Verification
The bench runs the core in lockstep with an arithmetic instruction-level model over a long generated program. The program uses random register values, including immediates with bit 15 set. A core that sign-extends the OR immediate, or zero-extends load, store or branch offsets, produces a wrong address or a wrong register and is caught at the next store or at the final dump. Writes aimed at register 0 and undefined encodings are mixed into the stream, so a core that lets either one change state shows a nonzero or stale value in a later store. A fixed sequence of jumps and a backward branch checks negative branch offsets and the jump address. A wrong taken or not-taken decision on equal or unequal registers appears as an instruction address mismatch in the very next cycle.

// File: rtl/onecycle_pkg.sv
package onecycle_pkg;
  localparam int XLEN   = 32;
  localparam int RSEL_W = 5;
  localparam int IMM_W  = 16;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    src_imm;
    logic    imm_zext;
    logic    mem_to_reg;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/onecycle_regfile.sv
module onecycle_regfile #(
  parameter int W     = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [W-1:0]     wdata,
  input  logic [SEL_W-1:0] asel,
  input  logic [SEL_W-1:0] bsel,
  output logic [W-1:0]     adata,
  output logic [W-1:0]     bdata
);
  localparam int DEPTH = 1 << SEL_W;

  logic [W-1:0] regs [DEPTH];

  // Array without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we && (wsel != '0)) regs[wsel] <= wdata;
  end

  assign adata = (asel == '0) ? '0 : regs[asel];
  assign bdata = (bsel == '0) ? '0 : regs[bsel];
endmodule

// File: rtl/onecycle_decode.sv
module onecycle_decode
  import onecycle_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_RTYPE: begin
        if ((funct == FN_ADD) && (shamt == '0)) begin
          ctrl.reg_write = 1'b1;
          ctrl.dst_rd    = 1'b1;
          ctrl.alu_op    = ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.reg_write = 1'b1;
        ctrl.src_imm   = 1'b1;
        ctrl.imm_zext  = 1'b1;
        ctrl.alu_op    = ALU_OR;
      end
      OP_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.src_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_op     = ALU_ADD;
      end
      OP_STORE: begin
        ctrl.mem_write = 1'b1;
        ctrl.src_imm   = 1'b1;
        ctrl.alu_op    = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/onecycle_alu.sv
module onecycle_alu
  import onecycle_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/onecycle_nextpc.sv
module onecycle_nextpc #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [W-1:0]     pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] target,
  input  logic             branch,
  input  logic             jump,
  input  logic             zero,
  output logic [W-1:0]     pc_next
);
  localparam int HI_W = W - TGT_W - 2;

  logic [W-1:0] pc_seq;
  logic [W-1:0] pc_br;
  logic [W-1:0] pc_jmp;

  assign pc_seq = pc + W'(4);
  assign pc_br  = pc_seq + {{(W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign pc_jmp = {pc_seq[W-1 -: HI_W], target, 2'b00};

  always_comb begin
    if (jump)                 pc_next = pc_jmp;
    else if (branch && zero)  pc_next = pc_br;
    else                      pc_next = pc_seq;
  end
endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
  import onecycle_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_instr,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_next;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic [XLEN-1:0]   wb_data;
  logic              alu_zero;
  logic              rf_we;
  logic [RSEL_W-1:0] dst_sel;
  ctrl_t             ctrl;

  onecycle_decode u_dec (
    .opcode (imem_instr[31:26]),
    .shamt  (imem_instr[10:6]),
    .funct  (imem_instr[5:0]),
    .ctrl   (ctrl)
  );

  assign dst_sel = ctrl.dst_rd ? imem_instr[15:11] : imem_instr[20:16];
  assign rf_we   = ctrl.reg_write & ~rst;

  onecycle_regfile #(.W(XLEN), .SEL_W(RSEL_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .wsel  (dst_sel),
    .wdata (wb_data),
    .asel  (imem_instr[25:21]),
    .bsel  (imem_instr[20:16]),
    .adata (rs_val),
    .bdata (rt_val)
  );

  assign imm_ext = ctrl.imm_zext ? {{EXT_W{1'b0}}, imem_instr[15:0]}
                                 : {{EXT_W{imem_instr[15]}}, imem_instr[15:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  onecycle_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  onecycle_nextpc #(.W(XLEN), .IMM_W(IMM_W), .TGT_W(26)) u_npc (
    .pc      (pc_q),
    .imm     (imem_instr[15:0]),
    .target  (imem_instr[25:0]),
    .branch  (ctrl.branch),
    .jump    (ctrl.jump),
    .zero    (alu_zero),
    .pc_next (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_write & ~rst;

  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00); // R7

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.branch || ctrl.jump) |=> pc_q == $past(pc_q) + 32'd4); // R9

  AST_BEQ_TAKEN_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && alu_zero) |-> rs_val == rt_val); // R6

  AST_ORI_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rf_we && ctrl.imm_zext) |-> wb_data[31:16] == rs_val[31:16]); // R3

  AST_SINGLE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_write, ctrl.mem_write, ctrl.branch, ctrl.jump})); // R5
endmodule

// File: tb/test_onecycle_core.sv
`timescale 1ns/1ps
module test_onecycle_core;
  localparam int IMEM_WORDS  = 1024;
  localparam int DMEM_WORDS  = 256;
  localparam int BODY_LEN    = 400;
  localparam int CYCLE_LIMIT = 5000;
  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_instr, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem    [IMEM_WORDS];
  logic [31:0] dmem    [DMEM_WORDS];
  logic [31:0] ref_mem [DMEM_WORDS];
  logic [31:0] ref_reg [32];
  logic [31:0] ref_pc;

  int n_checks = 0;
  int n_fail   = 0;
  int wp       = 0;

  always #10 clk = ~clk;

  onecycle_core i_onecycle_core (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_instr (imem_instr),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_instr = imem[imem_addr[IA_W+1:2]];
  assign dmem_rdata = dmem[dmem_addr[DA_W+1:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[DA_W+1:2]] <= dmem_wdata;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [4:0] sh, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input int word_idx);
    return {6'h02, 26'(word_idx)};
  endfunction

  task automatic put(input logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  // Architectural model: one instruction per call.
  task automatic step(output string req, output bit st,
                      output logic [31:0] ea, output logic [31:0] ed);
    logic [31:0] ins, a, b, sx, zx, npc, addr;
    int rs, rt, rd;
    ins = imem[ref_pc[IA_W+1:2]];
    rs = int'(ins[25:21]);
    rt = int'(ins[20:16]);
    rd = int'(ins[15:11]);
    a  = ref_reg[rs];
    b  = ref_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    npc = ref_pc + 32'd4;
    st = 1'b0; ea = '0; ed = '0;
    addr = a + sx;
    case (ins[31:26])
      6'h00: begin
        if (ins[5:0] == 6'h20 && ins[10:6] == 5'd0) begin
          req = (rd == 0) ? "R8" : "R2";
          if (rd != 0) ref_reg[rd] = a + b;
        end else req = "R9";
      end
      6'h0D: begin
        req = (rt == 0) ? "R8" : "R3";
        if (rt != 0) ref_reg[rt] = a | zx;
      end
      6'h23: begin
        req = (rt == 0) ? "R8" : "R4";
        if (rt != 0) ref_reg[rt] = ref_mem[addr[DA_W+1:2]];
      end
      6'h2B: begin
        req = "R5";
        st = 1'b1; ea = addr; ed = b;
        ref_mem[addr[DA_W+1:2]] = b;
      end
      6'h04: begin
        req = "R6";
        if (a == b) npc = ref_pc + 32'd4 + (sx << 2);
      end
      6'h02: begin
        req = "R7";
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: req = "R9";
    endcase
    ref_pc = npc;
  endtask

  initial begin
    logic [31:0] seed, s2, halt_pc, ea, ed;
    int body_end, kind, dst, sa, sb, off, cyc, gp;
    logic [5:0] op;
    logic [4:0] sh;
    string req, req_prev;
    bit st;

    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = 32'hFC00_0000;
    for (int i = 0; i < DMEM_WORDS; i++) begin
      dmem[i]    = 32'hA5A5_0000 ^ (i * 32'h0101_0037);
      ref_mem[i] = dmem[i];
    end
    for (int i = 0; i < 32; i++) ref_reg[i] = '0;

    // Prologue: every register gets a known value; r20 is the memory base 0x200.
    for (int k = 1; k < 32; k++)
      put(enc_i(6'h0D, 0, k, (k == 20) ? 16'h0200 : 16'((k * 16'h0917) ^ 16'h8421)));

    body_end = wp + BODY_LEN;
    seed = 32'h1357_9BDF;
    while (wp < body_end) begin
      seed = xs(seed);
      s2   = xs(seed ^ 32'h6A09_E667);
      kind = int'(seed % 10);
      dst  = int'(seed[12:9]);
      sa   = seed[23] ? 20 : int'(seed[16:13]);
      sb   = int'(seed[20:17]);
      off  = int'(s2[1:0]);
      if (wp + 1 + off > body_end) off = 0;
      case (kind)
        0, 1, 2: put(enc_r(sa, sb, dst, 5'd0, 6'h20));
        3, 4:    put(enc_i(6'h0D, sa, dst, s2[31:16]));
        5:       put(enc_i(6'h23, 20, dst, 16'((int'(s2[9:2]) - 128) * 4)));
        6:       put(enc_i(6'h2B, 20, sb,  16'((int'(s2[9:2]) - 128) * 4)));
        7:       put(enc_i(6'h04, sa, seed[21] ? sa : sb, 16'(off)));
        8:       put(enc_j(wp + 1 + off));
        default: begin
          if (seed[22]) begin
            sh = s2[10:6];
            if (s2[5:0] == 6'h20 && sh == 5'd0) sh = 5'd1;
            put(enc_r(sa, sb, dst, sh, s2[5:0]));
          end else begin
            op = s2[31:26];
            if (op == 6'h00 || op == 6'h02 || op == 6'h04 || op == 6'h0D ||
                op == 6'h23 || op == 6'h2B) op = 6'h3F;
            put({op, s2[25:0]});
          end
        end
      endcase
    end

    // Backward branch gadget: gp -> gp+2 -> (beq -2) gp+1 -> gp+3
    gp = wp;
    put(enc_j(gp + 2));
    put(enc_j(gp + 3));
    put(enc_i(6'h04, 0, 0, 16'hFFFE));
    // Unequal registers must not branch: r20 (0x200) vs r0
    put(enc_i(6'h04, 20, 0, 16'h0001));
    put(enc_i(6'h0D, 0, 0, 16'hFFFF));
    // Dump every register to words 0..31
    for (int k = 0; k < 32; k++) put(enc_i(6'h2B, 0, k, 16'(k * 4)));
    halt_pc = 32'(wp * 4);
    put(enc_j(wp));

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1", "imem_addr in reset", imem_addr, 32'h0);
      chk("R1", "dmem_we in reset", {31'b0, dmem_we}, 32'h0);
    end
    rst = 1'b0;
    ref_pc = '0;
    req_prev = "R1";
    cyc = 0;
    while (ref_pc != halt_pc && cyc < CYCLE_LIMIT) begin
      chk(req_prev, "imem_addr", imem_addr, ref_pc);
      step(req, st, ea, ed);
      if (st) begin
        chk("R5", "dmem_we", {31'b0, dmem_we}, 32'h1);
        chk("R5", "dmem_addr", dmem_addr, ea);
        chk("R5", "dmem_wdata", dmem_wdata, ed);
      end else begin
        chk(req, "dmem_we", {31'b0, dmem_we}, 32'h0);
      end
      req_prev = req;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= CYCLE_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d cycles expected < %0d", cyc, CYCLE_LIMIT);
    end
    chk(req_prev, "halt address", imem_addr, halt_pc);
    repeat (2) @(negedge clk);
    chk("R8", "dumped r0", dmem[0], 32'h0);
    for (int i = 0; i < DMEM_WORDS; i++)
      chk((i < 32) ? "R2" : "R4", "data memory word", dmem[i], ref_mem[i]);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule